// File: doc/BRIEF.md
# Qualified Fault Input Latch

This block watches four asynchronous fault pins and decides when a fault is real. Each pin first passes through a two-flop synchronizer. The synchronized level is then sampled on a fixed cadence. The first sample falls two bus cycles after the level goes high, and every later sample follows four cycles after the one before. A channel declares a fault once a programmable number of consecutive high samples has been collected. Any low level before that point starts the count over.

A declared fault sets a sticky per-channel flag, and that flag drives the channel's interrupt line. Software clears a flag by writing a one to its bit in the status word. A second word holds a 2-bit sample-count code for each channel, and a write-protect input freezes it. A per-channel enable input arms detection. Detection does not depend on anything downstream being active.

Top module: `fault_qual_latch`

## Requirements
- R1: After reset, both readable words return zero and every irq output is low.
- R2: The status word (reg_sel=0) carries the flag of channel c at bit 2c (channel 3 at bit 6, channel 0 at bit 0), and all odd bits always read zero.
- R3: Take a pin that rises just after one clock edge and then stays high. Counting that next edge as the first, its flag becomes visible after edge 4 + 4*(N-1), where N is the configured sample count, and not one edge earlier.
- R4: The 2-bit code of channel c sits at bits [2c+1:2c] of the qualify word (reg_sel=1): 00 selects 1 sample, 01 selects 2, 10 selects 4 and 11 selects 8.
- R5: A low synchronized level before the count completes discards the samples already collected, and qualification restarts from the next high level.
- R6: One continuous high period qualifies at most once. If software clears the flag while the pin stays high, the flag stays clear until the pin goes low and rises again.
- R7: A status write with a one at bit 2c clears flag c. A zero at that bit, or any write to an odd bit, leaves the flag unchanged.
- R8: irq[c] equals flag c at all times, so clearing the flag removes the request.
- R9: The qualify word is always readable. A write to it is ignored while wr_protect is high.
- R10: While chan_en[c] is low, channel c never qualifies a fault, but its flag keeps its value and can still be cleared.
- R11: If a clear write and a new qualification of the same channel fall on the same edge, the flag ends set.
- R12: Channels are independent: activity on one pin never changes another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| fault_pin | input | NUM_CH | Asynchronous fault inputs |
| chan_en | input | NUM_CH | Per-channel detection enable |
| wr_protect | input | 1 | Freezes the qualify word when high |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the qualify word |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 2*NUM_CH | Write data |
| reg_rdata | output | 2*NUM_CH | Read data of the selected word (combinational) |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: four channels, a two-stage synchronizer, a first sample after two cycles and a four-cycle sample period. With these values the longest qualification window, eight samples, is only 32 edges long. That lets the vector table reach the exact boundary edge for every code on every channel, and each boundary is checked one edge short of it as well. Short default windows also make it cheap to line up the edge where a clear write meets a qualification, and to interrupt a count partway through.

// File: rtl/fql_pkg.sv
package fql_pkg;
  localparam int QCODE_W = 2;
  localparam int QCNT_W  = 4;

  // code k requests 2**k consecutive high samples
  function automatic logic [QCNT_W-1:0] samples_needed(input logic [QCODE_W-1:0] code);
    return QCNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/fql_sync.sv
module fql_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_async;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fql_channel.sv
module fql_channel
  import fql_pkg::*;
#(
  parameter int FIRST_DLY = 2,
  parameter int PERIOD    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               lvl,
  input  logic [QCODE_W-1:0] code,
  output logic               qualify
);
  localparam int TMAX  = (FIRST_DLY > PERIOD) ? FIRST_DLY : PERIOD;
  localparam int TMR_W = $clog2(TMAX + 1);

  logic [TMR_W-1:0]  tmr;
  logic [QCNT_W-1:0] cnt;
  logic              done;
  logic [TMR_W-1:0]  tgt;
  logic [QCNT_W-1:0] need;
  logic [QCNT_W-1:0] cnt_inc;
  logic              sample_hit;

  always_comb begin
    tgt        = (cnt == '0) ? TMR_W'(FIRST_DLY - 1) : TMR_W'(PERIOD - 1);
    need       = samples_needed(code);
    cnt_inc    = cnt + QCNT_W'(1);
    sample_hit = en && lvl && !done && (tmr == tgt);
    qualify    = sample_hit && (cnt_inc >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en || !lvl) begin
      tmr  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (qualify) begin
        done <= 1'b1;
        tmr  <= '0;
        cnt  <= '0;
      end else if (sample_hit) begin
        tmr <= '0;
        cnt <= cnt_inc;
      end else begin
        tmr <= tmr + TMR_W'(1);
      end
    end
  end

  assert_qual_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |-> (lvl && $past(lvl)));
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr == '0 && cnt == '0 && !qualify));
  assert_low_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |=> (cnt == '0));
  assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |=> !qualify);
endmodule

// File: rtl/fql_regs.sv
module fql_regs
  import fql_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr_en,
  input  logic [QCODE_W*NUM_CH-1:0] wdata,
  input  logic                      wr_protect,
  input  logic [NUM_CH-1:0]         qual_set,
  output logic [QCODE_W*NUM_CH-1:0] rdata,
  output logic [NUM_CH-1:0]         flags,
  output logic [QCODE_W*NUM_CH-1:0] qcodes
);
  localparam int DW = QCODE_W * NUM_CH;

  logic [NUM_CH-1:0] clr_req;
  logic [DW-1:0]     status_word;
  logic              qual_wr;

  assign qual_wr = wr_en && sel && !wr_protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qcodes <= '0;
    else if (qual_wr) qcodes <= wdata;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    assign clr_req[c] = wr_en && !sel && wdata[QCODE_W*c];
    assign status_word[QCODE_W*c]   = flags[c];
    assign status_word[QCODE_W*c+1] = 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[c] <= 1'b0;
      else if (qual_set[c]) flags[c] <= 1'b1;
      else if (clr_req[c]) flags[c] <= 1'b0;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      qual_set[c] |=> flags[c]);
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[c] && !qual_set[c]) |=> !flags[c]);
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req[c] && !qual_set[c]) |=> $stable(flags[c]));
  end

  assign rdata = sel ? qcodes : status_word;

  assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |=> $stable(qcodes));
endmodule

// File: rtl/fault_qual_latch.sv
module fault_qual_latch
  import fql_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FIRST_DLY   = 2,
  parameter int PERIOD      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         fault_pin,
  input  logic [NUM_CH-1:0]         chan_en,
  input  logic                      wr_protect,
  input  logic                      reg_sel,
  input  logic                      reg_wr_en,
  input  logic [QCODE_W*NUM_CH-1:0] reg_wdata,
  output logic [QCODE_W*NUM_CH-1:0] reg_rdata,
  output logic [NUM_CH-1:0]         irq
);
  logic [NUM_CH-1:0]         pin_lvl;
  logic [NUM_CH-1:0]         qual_set;
  logic [NUM_CH-1:0]         flags;
  logic [QCODE_W*NUM_CH-1:0] qcodes;

  fql_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fault_pin), .q(pin_lvl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fql_channel #(.FIRST_DLY(FIRST_DLY), .PERIOD(PERIOD)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(chan_en[c]), .lvl(pin_lvl[c]),
      .code(qcodes[QCODE_W*c +: QCODE_W]), .qualify(qual_set[c])
    );
  end

  fql_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr_en(reg_wr_en),
    .wdata(reg_wdata), .wr_protect(wr_protect), .qual_set(qual_set),
    .rdata(reg_rdata), .flags(flags), .qcodes(qcodes)
  );

  assign irq = flags;

  assert_irq_follows_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq[0]) |-> $past(reg_wr_en && !reg_sel && reg_wdata[0]));
endmodule

// File: tb/test_fault_qual_latch.sv
module test_fault_qual_latch;
  localparam int NCH = 4;
  localparam int DW  = 2 * NCH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] fault_pin = '0;
  logic [NCH-1:0] chan_en = '1;
  logic          wr_protect = 1'b0;
  logic          reg_sel = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fault_qual_latch i_fault_qual_latch (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .chan_en(chan_en),
    .wr_protect(wr_protect), .reg_sel(reg_sel), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // edges from pin rise until the flag shows: sync 2 + first 2 + period 4 per extra sample
  function automatic int edges_for(input int code);
    return 4 + 4 * ((1 << code) - 1);
  endfunction

  // {ch[12:11], code[10:9], hold[8:1], expected flag[0]}
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 2'd0, 8'd4,  1'b1}, {2'd0, 2'd0, 8'd3,  1'b0},
    {2'd1, 2'd1, 8'd8,  1'b1}, {2'd1, 2'd1, 8'd7,  1'b0},
    {2'd2, 2'd2, 8'd16, 1'b1}, {2'd2, 2'd2, 8'd15, 1'b0},
    {2'd3, 2'd3, 8'd32, 1'b1}, {2'd3, 2'd3, 8'd31, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_word(input logic sel, output logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic pin_high(input int ch, input int n);
    @(negedge clk);
    fault_pin[ch] = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pin_low(input int ch);
    @(negedge clk);
    fault_pin[ch] = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    read_word(1'b0, rd); check("R1 status", rd, 0);
    read_word(1'b1, rd); check("R1 qualify", rd, 0);
    check("R1 irq", irq, 0);

    // R3 R4 R12 vector table
    for (int i = 0; i < 8; i++) begin
      int ch; int code; int hold; logic ex;
      ch = VEC[i][12:11]; code = VEC[i][10:9]; hold = VEC[i][8:1]; ex = VEC[i][0];
      check("R3 table consistency", ex, (hold >= edges_for(code)));
      reg_write(1'b1, DW'(code) << (2 * ch));
      reg_write(1'b0, 8'h55);
      pin_high(ch, hold);
      reg_sel = 1'b0; #1;
      check("R3 R4 R12 status", reg_rdata, DW'(ex) << (2 * ch));
      check("R8 irq", irq, NCH'(ex) << ch);
      pin_low(ch);
      reg_write(1'b0, 8'h55);
    end

    // R7 R8 write-one-to-clear on channel 0 (code 00)
    reg_write(1'b1, 8'h00);
    pin_high(0, 4); pin_low(0);
    reg_write(1'b0, 8'h00); read_word(1'b0, rd); check("R7 zero write keeps", rd, 8'h01);
    reg_write(1'b0, 8'h04); read_word(1'b0, rd); check("R7 other bit keeps", rd, 8'h01);
    reg_write(1'b0, 8'h01); read_word(1'b0, rd); check("R7 one clears", rd, 8'h00);
    check("R8 irq cleared", irq, 0);

    // R2 layout and odd bits
    pin_high(1, 4); pin_low(1); pin_high(3, 4); pin_low(3);
    reg_write(1'b0, 8'hAA); read_word(1'b0, rd); check("R2 layout", rd, 8'h44);
    check("R8 irq pair", irq, 4'b1010);
    reg_write(1'b0, 8'h55);

    // R9 write protect
    reg_write(1'b1, 8'hE4); read_word(1'b1, rd); check("R9 readback", rd, 8'hE4);
    wr_protect = 1'b1;
    reg_write(1'b1, 8'h1B); read_word(1'b1, rd); check("R9 protected", rd, 8'hE4);
    wr_protect = 1'b0;
    reg_write(1'b1, 8'h04); // ch1 code 01 (2 samples), others 1 sample

    // R5 interrupted count restarts
    pin_high(1, 5); pin_low(1);
    pin_high(1, 5); reg_sel = 1'b0; #1; check("R5 restart", reg_rdata, 0);
    repeat (3) @(posedge clk); #1; check("R5 completes", reg_rdata, 8'h04);
    pin_low(1); reg_write(1'b0, 8'h55);

    // R6 single qualification per high period
    pin_high(0, 4); reg_sel = 1'b0; #1; check("R6 first set", reg_rdata, 8'h01);
    reg_write(1'b0, 8'h01);
    repeat (10) @(posedge clk); #1; check("R6 no reset while high", reg_rdata, 0);
    pin_low(0);
    pin_high(0, 4); reg_sel = 1'b0; #1; check("R6 new edge sets", reg_rdata, 8'h01);
    pin_low(0); reg_write(1'b0, 8'h55);

    // R11 clear and set on the same edge
    @(negedge clk); fault_pin[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); reg_sel = 1'b0; reg_wdata = 8'h01; reg_wr_en = 1'b1;
    @(posedge clk); #1; check("R11 set wins", irq[0], 1'b1);
    @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0;
    pin_low(0);

    // R10 disabled channel keeps flag, does not qualify
    @(negedge clk); chan_en[0] = 1'b0;
    pin_high(0, 20); check("R10 flag retained", irq[0], 1'b1);
    reg_write(1'b0, 8'h01);
    repeat (20) @(posedge clk); #1; check("R10 no qualify", irq[0], 1'b0);
    pin_low(0);
    @(negedge clk); chan_en[0] = 1'b1;
    pin_high(0, 4); check("R10 re-enabled", irq[0], 1'b1);
    pin_low(0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule